// File: doc/BRIEF.md
# Multi-Line Frame Cache

This block stores frames: runs of consecutive, already-decoded instruction lines that begin at a known program counter and are meant to be fetched as a unit. One tag entry, holding the frame's full start PC, stands for a variable-length group of lines. The lines sit in the storage of one way, and the final line carries an end marker. A lookup by start PC that hits streams the frame's lines out, one per cycle, and stops after the marked line.

Frames enter through a fill port, one line per cycle. The lines collect in a staging buffer. The frame becomes visible only when its closing line has arrived and the whole frame has been copied into a way in a single commit cycle. A frame longer than a way can hold is discarded. The victim way is chosen in this order: a way already holding the same start PC, then an invalid way, then the least-recently-used way. An eviction port removes a frame by start PC when one of its speculative checks has failed. If the eviction names the frame that is waiting to commit, it cancels that commit.

Top module: `frame_cache`

## Requirements
- R1: After reset no frame is held: `lookupReady` and `fillReady` are 1, `rdValid` and `respValid` are 0, and every lookup misses.
- R2: A lookup accepted at a clock edge on a held frame of N lines (1 ≤ N ≤ `MAX_LINES`) returns `rdValid`=1 in the N cycles after that edge. Line i is returned in order, starting from line 0. `rdLast` is 1 on line N-1 only, and `rdValid` is 0 in the cycle after it.
- R3: Every accepted lookup gives `respValid`=1 in the next cycle, with `respHit` telling hit from miss. A miss returns no lines.
- R4: A frame of exactly `MAX_LINES` lines is stored. A frame with more lines is dropped whole, and any frame already held under that PC stays unchanged.
- R5: A frame whose closing line (`fillLast`=1) has not yet been accepted is never delivered. Lookups on its PC miss until it commits.
- R6: Each set holds up to `WAYS` frames, at most one per start PC. The set index is `pc[IDX_LSB +: log2(NUM_SETS)]`, and the full PC is the tag.
- R7: When a set is full, a new frame replaces the least-recently-used way. Both a lookup hit and a commit make a way most-recently-used.
- R8: An eviction of a held start PC makes later lookups on it miss and leaves the other frames in the set held.
- R9: An eviction naming the PC of a frame that is waiting to commit cancels that commit. The frame is never stored, and `fillReady` returns to 1 in the next cycle.
- R10: Filling a PC that is already held replaces that frame in its own way. No other frame in the set is displaced.
- R11: A commit takes place in the cycle after the closing line is accepted, unless a stream is in progress. `fillReady` is 0 from the closing line until the commit. `lookupReady` is 0 while a commit is pending and while lines are streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupPc | input | PC_W | Start PC to look up |
| lookupReady | output | 1 | Lookup accepted this cycle when valid |
| respValid | output | 1 | Hit/miss result of the previous accepted lookup |
| respHit | output | 1 | 1 on a hit |
| rdValid | output | 1 | A frame line is on `rdLine` |
| rdLine | output | LINE_W | Frame line data |
| rdLast | output | 1 | Current line is the final line of the frame |
| fillValid | input | 1 | Fill line present |
| fillPc | input | PC_W | Frame start PC (sampled on the first line) |
| fillLine | input | LINE_W | Fill line data |
| fillLast | input | 1 | Closing line of the frame |
| fillReady | output | 1 | Fill line accepted this cycle when valid |
| evictValid | input | 1 | Eviction request |
| evictPc | input | PC_W | Start PC of the frame to remove |

## Verification
The hardest cases to reach from the ports are the replacement cases. To get a least-recently-used victim that is not simply the oldest fill, the bench fills every way of one set, then makes a hit on a middle-aged frame, and only then adds another frame. It then checks which frame was displaced. The cancelled commit needs an eviction in the one cycle in which a closed frame is waiting. The bench places the eviction in the cycle right after the closing line, and only then looks the frame up.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic stageWr;      // write the fill line into the staging buffer
    logic stageClr;     // empty the staging buffer
    logic commit;       // copy the staged frame into its victim way
    logic evict;        // invalidate the way matching evictPc
    logic startStream;  // latch hit set/way, line pointer to zero
    logic advance;      // step the line pointer
  } fcStrobe_t;
endpackage

// File: rtl/fc_datapath.sv
module fc_datapath #(
  parameter int PC_W      = 32,
  parameter int LINE_W    = 32,
  parameter int NUM_SETS  = 64,
  parameter int WAYS      = 4,
  parameter int MAX_LINES = 4,
  parameter int IDX_LSB   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fc_pkg::fcStrobe_t strobes,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   fillPc,
  input  logic [PC_W-1:0]   evictPc,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              fillLast,
  output logic              lookupHit,
  output logic              curTerm,
  output logic              stageFull,
  output logic              evictPendMatch,
  output logic [LINE_W-1:0] rdLine
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
  localparam int CNT_W = $clog2(MAX_LINES + 1);

  // tag and state arrays
  logic [PC_W-1:0]   tagPc   [NUM_SETS][WAYS];
  logic              vld     [NUM_SETS][WAYS];
  logic [WAY_W-1:0]  age     [NUM_SETS][WAYS];
  logic [LINE_W-1:0] lineMem [NUM_SETS][WAYS][MAX_LINES];
  logic              termMem [NUM_SETS][WAYS][MAX_LINES];

  // staging buffer for a frame being filled
  logic [LINE_W-1:0] stageLine [MAX_LINES];
  logic              stageTerm [MAX_LINES];
  logic [CNT_W-1:0]  stageCnt;
  logic [PC_W-1:0]   stagePc;

  // stream pointer
  logic [SET_W-1:0]  strmSet;
  logic [WAY_W-1:0]  strmWay;
  logic [IDX_W-1:0]  strmIdx;

  logic [SET_W-1:0]  lkSet, evSet, cmSet, touchSet;
  logic [WAYS-1:0]   hitVec, evVec, cmMatch;
  logic [WAY_W-1:0]  hitWay, victim, touchWay;
  logic              touchEn, endSeen;

  assign lkSet = lookupPc[IDX_LSB +: SET_W];
  assign evSet = evictPc[IDX_LSB +: SET_W];
  assign cmSet = stagePc[IDX_LSB +: SET_W];

  // parallel tag compares
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w]  = vld[lkSet][w] && (tagPc[lkSet][w] == lookupPc);
    assign evVec[w]   = vld[evSet][w] && (tagPc[evSet][w] == evictPc);
    assign cmMatch[w] = vld[cmSet][w] && (tagPc[cmSet][w] == stagePc);
  end

  assign lookupHit      = |hitVec;
  assign evictPendMatch = (evictPc == stagePc);
  assign stageFull      = (stageCnt == CNT_W'(MAX_LINES));

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // victim: same PC, else lowest invalid way, else oldest way
  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && cmMatch[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[cmSet][w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && age[cmSet][w] == WAY_W'(WAYS - 1)) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  // recency update target
  always_comb begin
    touchEn  = strobes.startStream || strobes.commit;
    touchSet = strobes.startStream ? lkSet : cmSet;
    touchWay = strobes.startStream ? hitWay : victim;
  end

  // valid, tag and age state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          age[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (strobes.evict) begin
        for (int w = 0; w < WAYS; w++) begin
          if (evVec[w]) vld[evSet][w] <= 1'b0;
        end
      end
      if (strobes.commit) begin
        vld[cmSet][victim]   <= 1'b1;
        tagPc[cmSet][victim] <= stagePc;
      end
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            age[touchSet][w] <= '0;
          else if (age[touchSet][w] < age[touchSet][touchWay])
            age[touchSet][w] <= age[touchSet][w] + 1'b1;
        end
      end
    end
  end

  // line storage, written whole at commit
  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      for (int i = 0; i < MAX_LINES; i++) begin
        lineMem[cmSet][victim][i] <= stageLine[i];
        termMem[cmSet][victim][i] <= stageTerm[i];
      end
    end
  end

  // staging buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageCnt <= '0;
      stagePc  <= '0;
    end else if (strobes.stageClr) begin
      stageCnt <= '0;
    end else if (strobes.stageWr) begin
      if (stageCnt == '0) stagePc <= fillPc;
      stageCnt <= stageCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.stageWr && !stageFull) begin
      stageLine[stageCnt[IDX_W-1:0]] <= fillLine;
      stageTerm[stageCnt[IDX_W-1:0]] <= fillLast;
    end
  end

  // stream pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strmSet <= '0;
      strmWay <= '0;
      strmIdx <= '0;
    end else if (strobes.startStream) begin
      strmSet <= lkSet;
      strmWay <= hitWay;
      strmIdx <= '0;
    end else if (strobes.advance) begin
      strmIdx <= strmIdx + 1'b1;
    end
  end

  assign rdLine  = lineMem[strmSet][strmWay][strmIdx];
  assign curTerm = termMem[strmSet][strmWay][strmIdx];

  // staged frame holds its closing line
  always_comb begin
    endSeen = 1'b0;
    for (int i = 0; i < MAX_LINES; i++) begin
      if (CNT_W'(i) < stageCnt && stageTerm[i]) endSeen = 1'b1;
    end
  end

  // R6
  onehot_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
  // R2
  stream_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> (strmIdx < IDX_W'(MAX_LINES - 1)));
  // R5
  whole_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> endSeen);
  // R9
  evict_beats_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evict && evictPendMatch) |-> !strobes.commit);
  // R11
  no_commit_in_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !strobes.startStream);
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic              fillValid,
  input  logic              fillLast,
  input  logic              evictValid,
  input  logic              lookupHit,
  input  logic              curTerm,
  input  logic              stageFull,
  input  logic              evictPendMatch,
  output fc_pkg::fcStrobe_t strobes,
  output logic              lookupReady,
  output logic              fillReady,
  output logic              respValid,
  output logic              respHit,
  output logic              rdValid,
  output logic              rdLast
);
  logic active, pending, dropping;
  logic lkAcc, fillAcc, cancel, closeOk;

  assign lookupReady = !active && !pending;
  assign fillReady   = !pending;
  assign lkAcc       = lookupValid && lookupReady;
  assign fillAcc     = fillValid && fillReady;
  assign cancel      = pending && evictValid && evictPendMatch;
  assign closeOk     = fillAcc && fillLast && !dropping && !stageFull;

  always_comb begin
    strobes.evict       = evictValid;
    strobes.startStream = lkAcc && lookupHit;
    strobes.advance     = active && !curTerm;
    strobes.commit      = pending && !active && !cancel;
    strobes.stageWr     = fillAcc && !dropping && !stageFull;
    strobes.stageClr    = strobes.commit || cancel
                        || (fillAcc && fillLast && (dropping || stageFull));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      pending   <= 1'b0;
      dropping  <= 1'b0;
      respValid <= 1'b0;
      respHit   <= 1'b0;
    end else begin
      if (strobes.startStream) active <= 1'b1;
      else if (active && curTerm) active <= 1'b0;

      if (closeOk) pending <= 1'b1;
      else if (strobes.commit || cancel) pending <= 1'b0;

      if (fillAcc && fillLast) dropping <= 1'b0;
      else if (fillAcc && stageFull) dropping <= 1'b1;

      respValid <= lkAcc;
      respHit   <= lkAcc && lookupHit;
    end
  end

  assign rdValid = active;
  assign rdLast  = active && curTerm;

  // R2
  hit_first_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> rdValid);
  // R4
  drop_not_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropping |-> !pending);
  // R3
  miss_no_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> !rdValid);
endmodule

// File: rtl/frame_cache.sv
module frame_cache #(
  parameter int PC_W      = 32,
  parameter int LINE_W    = 32,
  parameter int NUM_SETS  = 64,
  parameter int WAYS      = 4,
  parameter int MAX_LINES = 4,
  parameter int IDX_LSB   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              lookupReady,
  output logic              respValid,
  output logic              respHit,
  output logic              rdValid,
  output logic [LINE_W-1:0] rdLine,
  output logic              rdLast,
  input  logic              fillValid,
  input  logic [PC_W-1:0]   fillPc,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              fillLast,
  output logic              fillReady,
  input  logic              evictValid,
  input  logic [PC_W-1:0]   evictPc
);
  fc_pkg::fcStrobe_t strobes;
  logic lookupHit, curTerm, stageFull, evictPendMatch;

  fc_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .lookupValid    (lookupValid),
    .fillValid      (fillValid),
    .fillLast       (fillLast),
    .evictValid     (evictValid),
    .lookupHit      (lookupHit),
    .curTerm        (curTerm),
    .stageFull      (stageFull),
    .evictPendMatch (evictPendMatch),
    .strobes        (strobes),
    .lookupReady    (lookupReady),
    .fillReady      (fillReady),
    .respValid      (respValid),
    .respHit        (respHit),
    .rdValid        (rdValid),
    .rdLast         (rdLast)
  );

  fc_datapath #(
    .PC_W      (PC_W),
    .LINE_W    (LINE_W),
    .NUM_SETS  (NUM_SETS),
    .WAYS      (WAYS),
    .MAX_LINES (MAX_LINES),
    .IDX_LSB   (IDX_LSB)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .lookupPc       (lookupPc),
    .fillPc         (fillPc),
    .evictPc        (evictPc),
    .fillLine       (fillLine),
    .fillLast       (fillLast),
    .lookupHit      (lookupHit),
    .curTerm        (curTerm),
    .stageFull      (stageFull),
    .evictPendMatch (evictPendMatch),
    .rdLine         (rdLine)
  );
endmodule

// File: tb/sim_frame_cache.sv
`timescale 1ns/1ps
module sim_frame_cache;
  localparam int PC_W = 32;
  localparam int LINE_W = 32;
  localparam int MAXL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic lookupReady, respValid, respHit, rdValid, rdLast, fillReady;
  logic [LINE_W-1:0] rdLine;
  logic fillValid = 1'b0;
  logic [PC_W-1:0] fillPc = '0;
  logic [LINE_W-1:0] fillLine = '0;
  logic fillLast = 1'b0;
  logic evictValid = 1'b0;
  logic [PC_W-1:0] evictPc = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_cache u0 (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupReady(lookupReady),
    .respValid(respValid), .respHit(respHit),
    .rdValid(rdValid), .rdLine(rdLine), .rdLast(rdLast),
    .fillValid(fillValid), .fillPc(fillPc), .fillLine(fillLine),
    .fillLast(fillLast), .fillReady(fillReady),
    .evictValid(evictValid), .evictPc(evictPc)
  );

  function automatic logic [PC_W-1:0] mkPc(int tagv, int setv);
    return PC_W'((tagv << 8) | (setv << 2));
  endfunction

  function automatic logic [LINE_W-1:0] lineVal(logic [PC_W-1:0] pc, int i, int salt);
    return {pc[15:0] ^ 16'(salt), 16'(i)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doLookup(logic [PC_W-1:0] pc, bit expHit, int n, int salt, string req);
    @(negedge clk);
    while (!lookupReady) @(negedge clk);
    lookupValid = 1'b1;
    lookupPc = pc;
    @(negedge clk);
    lookupValid = 1'b0;
    chk(respValid == 1'b1, {req, " R3 respValid"}, 64'(respValid), 64'd1);
    chk(respHit == expHit, {req, " hit"}, 64'(respHit), 64'(expHit));
    if (expHit) begin
      for (int i = 0; i < n; i++) begin
        chk(rdValid && rdLine == lineVal(pc, i, salt), {req, " R2 line"},
            64'(rdLine), 64'(lineVal(pc, i, salt)));
        chk(rdLast == (i == n - 1), {req, " R2 last"}, 64'(rdLast), 64'(i == n - 1));
        if (i > 0) chk(!lookupReady, {req, " R11 busy"}, 64'(lookupReady), 64'd0);
        @(negedge clk);
      end
    end
    chk(rdValid == 1'b0, {req, " R2 end"}, 64'(rdValid), 64'd0);
  endtask

  task automatic sendLine(logic [PC_W-1:0] pc, int i, int salt, bit last);
    while (!fillReady) @(negedge clk);
    fillValid = 1'b1;
    fillPc = pc;
    fillLine = lineVal(pc, i, salt);
    fillLast = last;
    @(negedge clk);
    fillValid = 1'b0;
    fillLast = 1'b0;
  endtask

  task automatic doFill(logic [PC_W-1:0] pc, int n, int salt, bit expCommit);
    @(negedge clk);
    for (int i = 0; i < n; i++) sendLine(pc, i, salt, i == n - 1);
    if (expCommit) begin
      chk(!fillReady && !lookupReady, "R11 pending", 64'({fillReady, lookupReady}), 64'd0);
      @(negedge clk);
      chk(fillReady && lookupReady, "R11 commit", 64'({fillReady, lookupReady}), 64'd3);
    end
  endtask

  task automatic doEvict(logic [PC_W-1:0] pc);
    @(negedge clk);
    evictValid = 1'b1;
    evictPc = pc;
    @(negedge clk);
    evictValid = 1'b0;
  endtask

  task automatic testReset();
    chk(lookupReady && fillReady, "R1 ready", 64'({lookupReady, fillReady}), 64'd3);
    chk(!rdValid && !respValid, "R1 idle", 64'({rdValid, respValid}), 64'd0);
    doLookup(mkPc(1, 5), 1'b0, 0, 0, "R1 empty");
  endtask

  task automatic testBasic();
    doFill(mkPc(7, 3), 1, 1, 1'b1);
    doLookup(mkPc(7, 3), 1'b1, 1, 1, "R2 single");
    doFill(mkPc(2, 6), 3, 2, 1'b1);
    doLookup(mkPc(2, 6), 1'b1, 3, 2, "R2 three");
    doLookup(mkPc(2, 7), 1'b0, 0, 0, "R3 miss");
  endtask

  task automatic testLru();
    for (int k = 1; k <= 4; k++) doFill(mkPc(k, 5), 2, k, 1'b1);
    for (int k = 1; k <= 4; k++) doLookup(mkPc(k, 5), 1'b1, 2, k, "R6 four ways");
    // recency now: 1 oldest; hits in order 1..4 keep that order
    doFill(mkPc(5, 5), 3, 5, 1'b1);
    doLookup(mkPc(1, 5), 1'b0, 0, 0, "R7 oldest replaced");
    doLookup(mkPc(5, 5), 1'b1, 3, 5, "R6 new frame");
    doLookup(mkPc(2, 5), 1'b1, 2, 2, "R7 touch");
    doFill(mkPc(6, 5), 2, 6, 1'b1);
    doLookup(mkPc(3, 5), 1'b0, 0, 0, "R7 hit changes victim");
    doLookup(mkPc(2, 5), 1'b1, 2, 2, "R7 touched kept");
    doLookup(mkPc(4, 5), 1'b1, 2, 4, "R7 kept");
    doLookup(mkPc(6, 5), 1'b1, 2, 6, "R7 filled");
    doLookup(mkPc(2, 6), 1'b1, 3, 2, "R6 other set untouched");
  endtask

  task automatic testRefill();
    doFill(mkPc(2, 5), 1, 85, 1'b1);
    doLookup(mkPc(2, 5), 1'b1, 1, 85, "R10 replaced");
    doLookup(mkPc(4, 5), 1'b1, 2, 4, "R10 no displace a");
    doLookup(mkPc(5, 5), 1'b1, 3, 5, "R10 no displace b");
    doLookup(mkPc(6, 5), 1'b1, 2, 6, "R10 no displace c");
  endtask

  task automatic testOverflow();
    doFill(mkPc(9, 10), MAXL + 1, 9, 1'b0);
    doLookup(mkPc(9, 10), 1'b0, 0, 0, "R4 too long");
    doFill(mkPc(9, 10), MAXL, 9, 1'b1);
    doLookup(mkPc(9, 10), 1'b1, MAXL, 9, "R4 max length");
    doFill(mkPc(2, 5), MAXL + 2, 99, 1'b0);
    doLookup(mkPc(2, 5), 1'b1, 1, 85, "R4 old kept");
  endtask

  task automatic testPartial();
    @(negedge clk);
    sendLine(mkPc(3, 12), 0, 3, 1'b0);
    sendLine(mkPc(3, 12), 1, 3, 1'b0);
    doLookup(mkPc(3, 12), 1'b0, 0, 0, "R5 partial");
    @(negedge clk);
    sendLine(mkPc(3, 12), 2, 3, 1'b1);
    @(negedge clk);
    doLookup(mkPc(3, 12), 1'b1, 3, 3, "R5 complete");
  endtask

  task automatic testEvict();
    doEvict(mkPc(4, 5));
    doLookup(mkPc(4, 5), 1'b0, 0, 0, "R8 evicted");
    doLookup(mkPc(5, 5), 1'b1, 3, 5, "R8 neighbour kept");
    // eviction in the cycle a closed frame waits
    @(negedge clk);
    sendLine(mkPc(8, 20), 0, 8, 1'b0);
    sendLine(mkPc(8, 20), 1, 8, 1'b1);
    evictValid = 1'b1;
    evictPc = mkPc(8, 20);
    @(negedge clk);
    evictValid = 1'b0;
    chk(fillReady == 1'b1, "R9 cancel ready", 64'(fillReady), 64'd1);
    doLookup(mkPc(8, 20), 1'b0, 0, 0, "R9 never stored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testLru();
    testRefill();
    testOverflow();
    testPartial();
    testEvict();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule